// File: doc/BRIEF.md
# Prescaled Trigger Delay Counter

This block is a 16-bit delay counter that is launched by an edge on one selected trigger source. It counts at a programmable rate: the clock is divided by a decimal multiplier (1, 10, 20 or 40) times a power of two from 1 to 128. When the count reaches a programmable modulus, the counter either wraps and keeps running (continuous mode) or parks at the modulus until the next trigger (one-shot mode). An interrupt-delay compare raises a sticky flag when the count reaches a chosen value. The flag reaches the interrupt line only while the interrupt enable is set.

Software programs the block through a single-cycle write strobe with three addresses: control, modulus buffer and delay buffer. Writes to the modulus and delay buffers go to holding registers. The counter does not see the new values until a load request is armed and then committed under one of four load policies: at once, at the next modulus hit, at the next accepted trigger, or at whichever of those two comes first. The counter runs through the states Off, Idle, Run and Hold:
- Off goes to Idle on enable, or straight to Run on enable plus a trigger.
- Idle and Hold go to Run on a trigger.
- Run goes to Hold on a one-shot modulus hit.
- Any state goes to Off on disable.

The load sequencer runs through two states: Idle goes to Armed on a load request, and Armed goes back to Idle on commit or on disable.

Top module: `trig_delay_timer`

## Requirements
- R1: After reset, count is 0 and start_pulse, wrap_pulse, irq_flag, irq and ldok are all 0.
- R2: While the enable bit (control bit 0) is 0, count is held at 0 and every trigger is ignored. Clearing the enable bit returns count to 0 one cycle after the write.
- R3: Once started, count advances by one every M×2^P clock cycles. M is 1, 10, 20 or 40 for the multiplier field codes 0, 1, 2 and 3 (control bits 3:2). P is the prescale field, 0 to 7 (control bits 6:4).
- R4: Select codes 0 to 14 (control bits 10:7) pick hardware input trig_in[code]. Only a 0-to-1 transition on the selected input starts the counter. A held-high level, an edge on an unselected input, and a level that was already high when it became selected are all ignored.
- R5: With select code 15, a control write with the software trigger bit (bit 16) set starts the counter one cycle after the write. The software trigger bit has no effect under any other select code.
- R6: An accepted trigger clears count to 0 and raises start_pulse for exactly one cycle in the cycle count shows 0. This applies in Idle, Run and Hold alike.
- R7: In continuous mode (control bit 1 = 1), the tick that finds count equal to the modulus returns count to 0. wrap_pulse is high for one cycle together with that 0.
- R8: In one-shot mode (control bit 1 = 0), the tick that finds count equal to the modulus raises wrap_pulse for one cycle. Count then stays at the modulus until the next accepted trigger.
- R9: irq_flag sets in the cycle count takes a value equal to the working delay. It stays set until a control write has bit 14 equal to 0, and writing 1 to bit 14 does not set it. irq equals irq_flag gated by the interrupt enable (control bit 13).
- R10: Writes to address 1 (modulus buffer) and address 2 (delay buffer) change nothing until a commit. A control write with bit 15 and bit 0 both set arms the load, and ldok reads 1 until the commit. A control write with bit 15 set and bit 0 clear leaves ldok at 0.
- R11: Load mode 0 (control bits 12:11 = 00) commits one cycle after arming.
- R12: Load mode 1 commits on the tick where count equals the modulus. ldok is already 0 when that wrap_pulse is seen, and the new modulus governs the following period.
- R13: Load mode 2 commits on the next accepted trigger, and ldok stays 1 until then. Load mode 3 commits on the first of an accepted trigger or a modulus hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_addr | input | 2 | 0 control, 1 modulus buffer, 2 delay buffer |
| wr_data | input | 17 | Write data |
| trig_in | input | 15 | Hardware trigger inputs, synchronous to clk |
| count | output | 16 | Live counter value |
| start_pulse | output | 1 | One-cycle pulse when a trigger is accepted |
| wrap_pulse | output | 1 | One-cycle pulse on a modulus hit |
| irq_flag | output | 1 | Sticky interrupt-delay flag |
| irq | output | 1 | Flag gated by interrupt enable |
| ldok | output | 1 | Load request armed, commit pending |

## Verification
The assertions assume that trig_in is already synchronous to clk and that each write lasts exactly one cycle. They also assume wr_addr value 3 is never written with meaningful intent. The stimulus drives every input one nanosecond after a rising edge, holds the strobe for a single edge, and only changes trigger levels between edges. Because of this, every edge-detector history bit and every armed load sees one clean value per cycle. Modulus and delay values are always written to the buffers before the arming write, so no commit races a buffer update.

// File: rtl/tdt_pkg.sv
package tdt_pkg;
    localparam int ADDR_W = 2;
    localparam int SEL_W  = 4;
    localparam int N_HW   = (1 << SEL_W) - 1;
    localparam int PSC_W  = 3;
    localparam int MULT_W = 2;

    localparam logic [ADDR_W-1:0] A_CTL = 2'd0;
    localparam logic [ADDR_W-1:0] A_MOD = 2'd1;
    localparam logic [ADDR_W-1:0] A_DLY = 2'd2;

    // control word bit positions
    localparam int B_EN   = 0;
    localparam int B_CONT = 1;
    localparam int B_MULT = 2;
    localparam int B_PSC  = B_MULT + MULT_W;
    localparam int B_TSEL = B_PSC + PSC_W;
    localparam int B_LM   = B_TSEL + SEL_W;
    localparam int B_IE   = B_LM + 2;
    localparam int B_FLAG = B_IE + 1;
    localparam int B_LDOK = B_FLAG + 1;
    localparam int B_SW   = B_LDOK + 1;
    localparam int CTL_W  = B_SW + 1;

    typedef enum logic [1:0] {
        CS_OFF  = 2'd0,
        CS_IDLE = 2'd1,
        CS_RUN  = 2'd2,
        CS_HOLD = 2'd3
    } cnt_state_e;

    typedef enum logic [1:0] {
        LM_NOW    = 2'b00,
        LM_AT_MOD = 2'b01,
        LM_AT_TRG = 2'b10,
        LM_EITHER = 2'b11
    } load_mode_e;

    typedef enum logic {
        LS_IDLE  = 1'b0,
        LS_ARMED = 1'b1
    } load_state_e;

    typedef struct packed {
        logic              en;
        logic              cont;
        logic [MULT_W-1:0] mult;
        logic [PSC_W-1:0]  psel;
        logic [SEL_W-1:0]  tsel;
        load_mode_e        lmode;
        logic              ie;
    } ctl_t;
endpackage

// File: rtl/tdt_prescaler.sv
module tdt_prescaler
    import tdt_pkg::*;
#(
    parameter int P_W = PSC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              restart,
    input  logic [MULT_W-1:0] mult,
    input  logic [P_W-1:0]    psel,
    output logic              tick
);
    localparam int DIV_W = 6 + (1 << P_W) - 1;

    logic [DIV_W-1:0] mult_val;
    logic [DIV_W-1:0] divisor;
    logic [DIV_W-1:0] term;
    logic [DIV_W-1:0] pc_q;

    always_comb begin
        unique case (mult)
            2'd0:    mult_val = DIV_W'(1);
            2'd1:    mult_val = DIV_W'(10);
            2'd2:    mult_val = DIV_W'(20);
            default: mult_val = DIV_W'(40);
        endcase
        divisor = mult_val << psel;
        term    = divisor - DIV_W'(1);
        tick    = run && !restart && (pc_q >= term);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                  pc_q <= '0;
        else if (restart || !run)    pc_q <= '0;
        else if (tick)               pc_q <= '0;
        else                         pc_q <= pc_q + DIV_W'(1);
    end

    // R3: every tick starts a fresh division window
    assert_tick_realign_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (pc_q == '0))
        else $error("prescaler window not realigned after tick");
endmodule

// File: rtl/tdt_trigsel.sv
module tdt_trigsel
    import tdt_pkg::*;
#(
    parameter int S_W  = SEL_W,
    parameter int N_IN = N_HW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] hw_in,
    input  logic [S_W-1:0]  sel,
    input  logic            sw_req,
    output logic            trig_evt
);
    localparam logic [S_W-1:0] SW_CODE = {S_W{1'b1}};

    logic [N_IN-1:0] prev_q;
    logic [N_IN-1:0] rise;
    logic            hw_hit;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= hw_in;
    end

    always_comb begin
        rise   = hw_in & ~prev_q;
        hw_hit = 1'b0;
        for (int i = 0; i < N_IN; i++) begin
            if (sel == S_W'(i)) hw_hit = rise[i];
        end
        trig_evt = (sel == SW_CODE) ? sw_req : hw_hit;
    end

    // R4: a hardware edge cannot repeat on the next cycle from the same input
    assert_one_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_evt && (sel != SW_CODE)) |=> (!trig_evt || (sel != $past(sel))))
        else $error("held trigger level retriggered");
endmodule

// File: rtl/tdt_loader.sv
module tdt_loader
    import tdt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             arm_req,
    input  load_mode_e       mode,
    input  logic             wrap_evt,
    input  logic             trig_evt,
    input  logic [CNT_W-1:0] mod_buf,
    input  logic [CNT_W-1:0] dly_buf,
    output logic             ldok,
    output logic [CNT_W-1:0] mod_work,
    output logic [CNT_W-1:0] dly_work
);
    load_state_e st_q, st_d;
    logic        commit;
    logic [1:0]  mbits;

    always_comb begin
        mbits  = mode;
        commit = (st_q == LS_ARMED) && en &&
                 ((mode == LM_NOW) || (mbits[0] && wrap_evt) || (mbits[1] && trig_evt));
        st_d = st_q;
        unique case (st_q)
            LS_IDLE:  if (arm_req) st_d = LS_ARMED;
            LS_ARMED: if (arm_req) st_d = LS_ARMED;
                      else if (!en || commit) st_d = LS_IDLE;
            default:  st_d = LS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= LS_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mod_work <= '0;
            dly_work <= '0;
        end else if (commit) begin
            mod_work <= mod_buf;
            dly_work <= dly_buf;
        end
    end

    assign ldok = (st_q == LS_ARMED);

    // R11: immediate policy clears the request on the next edge
    assert_now_commit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LS_ARMED && en && mode == LM_NOW && !arm_req) |=> !ldok)
        else $error("immediate load did not commit");

    // R10: working values move only out of the armed state
    assert_work_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LS_IDLE) |=> ($stable(mod_work) && $stable(dly_work)))
        else $error("working value changed without armed load");
endmodule

// File: rtl/tdt_counter.sv
module tdt_counter
    import tdt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             cont,
    input  logic             trig_evt,
    input  logic             tick,
    input  logic [CNT_W-1:0] mod_work,
    input  logic [CNT_W-1:0] dly_work,
    output logic [CNT_W-1:0] cnt_q,
    output logic             start_pulse,
    output logic             wrap_pulse,
    output logic             wrap_evt,
    output logic             accept,
    output logic             dly_hit,
    output logic             run
);
    cnt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_d;
    logic             at_mod;
    logic             step_up;
    logic             cnt_load;

    always_comb begin
        accept   = en && trig_evt;
        at_mod   = (cnt_q == mod_work);
        wrap_evt = en && !accept && (state_q == CS_RUN) && tick && at_mod;
        step_up  = en && !accept && (state_q == CS_RUN) && tick && !at_mod;
        state_d  = state_q;
        unique case (state_q)
            CS_OFF:           if (accept) state_d = CS_RUN;
                              else if (en) state_d = CS_IDLE;
            CS_IDLE, CS_HOLD: if (!en) state_d = CS_OFF;
                              else if (accept) state_d = CS_RUN;
            CS_RUN:           if (!en) state_d = CS_OFF;
                              else if (wrap_evt && !cont) state_d = CS_HOLD;
            default:          state_d = CS_OFF;
        endcase
    end

    always_comb begin
        cnt_d    = cnt_q;
        cnt_load = 1'b0;
        if (!en) begin
            cnt_d = '0;
        end else if (accept) begin
            cnt_d    = '0;
            cnt_load = 1'b1;
        end else if (wrap_evt) begin
            if (cont) begin
                cnt_d    = '0;
                cnt_load = 1'b1;
            end
        end else if (step_up) begin
            cnt_d    = cnt_q + CNT_W'(1);
            cnt_load = 1'b1;
        end
        dly_hit = cnt_load && (cnt_d == dly_work);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CS_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            start_pulse <= 1'b0;
            wrap_pulse  <= 1'b0;
        end else begin
            cnt_q       <= cnt_d;
            start_pulse <= accept;
            wrap_pulse  <= wrap_evt;
        end
    end

    assign run = (state_q == CS_RUN);

    // R2: disabled counter reads zero
    assert_off_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt_q == '0))
        else $error("count not cleared while disabled");

    // R6: start pulse coincides with a zero count
    assert_start_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> (cnt_q == '0))
        else $error("start pulse with nonzero count");

    // R7: continuous wrap returns to zero with the wrap pulse
    assert_cont_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_evt && cont) |=> ((cnt_q == '0) && wrap_pulse))
        else $error("continuous wrap failed");

    // R8: parked counter does not move without a trigger
    assert_hold_still_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CS_HOLD && en && !trig_evt) |=> $stable(cnt_q))
        else $error("count moved in hold");

    // R3: no tick, no trigger, no movement while running
    assert_no_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CS_RUN && en && !trig_evt && !tick) |=> $stable(cnt_q))
        else $error("count moved without tick");
endmodule

// File: rtl/trig_delay_timer.sv
module trig_delay_timer
    import tdt_pkg::*;
#(
    parameter int  CNT_W = 16,
    localparam int WR_W  = (CNT_W > CTL_W) ? CNT_W : CTL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WR_W-1:0]   wr_data,
    input  logic [N_HW-1:0]   trig_in,
    output logic [CNT_W-1:0]  count,
    output logic              start_pulse,
    output logic              wrap_pulse,
    output logic              irq_flag,
    output logic              irq,
    output logic              ldok
);
    ctl_t             ctl_q;
    logic             sw_req_q;
    logic             flag_q;
    logic [CNT_W-1:0] mod_buf, dly_buf, mod_work, dly_work;
    logic             ctl_wr, arm_req;
    logic             trig_evt, tick, run, accept, wrap_evt, dly_hit;

    assign ctl_wr  = wr_en && (wr_addr == A_CTL);
    assign arm_req = ctl_wr && wr_data[B_LDOK] && wr_data[B_EN];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            sw_req_q <= 1'b0;
        end else begin
            sw_req_q <= ctl_wr && wr_data[B_SW];
            if (ctl_wr) begin
                ctl_q.en    <= wr_data[B_EN];
                ctl_q.cont  <= wr_data[B_CONT];
                ctl_q.mult  <= wr_data[B_MULT +: MULT_W];
                ctl_q.psel  <= wr_data[B_PSC +: PSC_W];
                ctl_q.tsel  <= wr_data[B_TSEL +: SEL_W];
                ctl_q.lmode <= load_mode_e'(wr_data[B_LM +: 2]);
                ctl_q.ie    <= wr_data[B_IE];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mod_buf <= '0;
            dly_buf <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_MOD) mod_buf <= wr_data[CNT_W-1:0];
            if (wr_addr == A_DLY) dly_buf <= wr_data[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                         flag_q <= 1'b0;
        else if (dly_hit)                   flag_q <= 1'b1;
        else if (ctl_wr && !wr_data[B_FLAG]) flag_q <= 1'b0;
    end

    tdt_trigsel #(.S_W(SEL_W), .N_IN(N_HW)) u_trigsel (
        .clk      (clk),
        .rst_n    (rst_n),
        .hw_in    (trig_in),
        .sel      (ctl_q.tsel),
        .sw_req   (sw_req_q),
        .trig_evt (trig_evt)
    );

    tdt_prescaler #(.P_W(PSC_W)) u_prescaler (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (accept),
        .mult    (ctl_q.mult),
        .psel    (ctl_q.psel),
        .tick    (tick)
    );

    tdt_loader #(.CNT_W(CNT_W)) u_loader (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (ctl_q.en),
        .arm_req  (arm_req),
        .mode     (ctl_q.lmode),
        .wrap_evt (wrap_evt),
        .trig_evt (accept),
        .mod_buf  (mod_buf),
        .dly_buf  (dly_buf),
        .ldok     (ldok),
        .mod_work (mod_work),
        .dly_work (dly_work)
    );

    tdt_counter #(.CNT_W(CNT_W)) u_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (ctl_q.en),
        .cont        (ctl_q.cont),
        .trig_evt    (trig_evt),
        .tick        (tick),
        .mod_work    (mod_work),
        .dly_work    (dly_work),
        .cnt_q       (count),
        .start_pulse (start_pulse),
        .wrap_pulse  (wrap_pulse),
        .wrap_evt    (wrap_evt),
        .accept      (accept),
        .dly_hit     (dly_hit),
        .run         (run)
    );

    assign irq_flag = flag_q;
    assign irq      = flag_q && ctl_q.ie;

    // R9: a clearing write without a simultaneous hit drops the flag
    assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !wr_data[B_FLAG] && !dly_hit) |=> !irq_flag)
        else $error("flag not cleared by write");
endmodule

// File: tb/trig_delay_timer_bench.sv
module trig_delay_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [16:0] wr_data = '0;
    logic [14:0] trig_in = '0;
    logic [15:0] count;
    logic        start_pulse, wrap_pulse, irq_flag, irq, ldok;

    int total = 0;
    int fails = 0;

    // {multiplier code, prescale code, expected divisor}
    localparam int VEC [8][3] = '{
        '{0, 0, 1}, '{1, 0, 10}, '{2, 1, 40}, '{3, 0, 40},
        '{0, 3, 8}, '{1, 2, 40}, '{0, 7, 128}, '{3, 2, 160}
    };

    always #2 clk = ~clk;

    trig_delay_timer u_trig_delay_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .trig_in(trig_in), .count(count),
        .start_pulse(start_pulse), .wrap_pulse(wrap_pulse),
        .irq_flag(irq_flag), .irq(irq), .ldok(ldok)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input int a, input logic [16:0] d);
        wr_en = 1'b1; wr_addr = a[1:0]; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    function automatic logic [16:0] ctl(input bit en, input bit cont, input int mult,
                                         input int ps, input int sel, input int lm,
                                         input bit ie, input bit keep, input bit ld, input bit sw);
        logic [16:0] r;
        r = '0;
        r[0] = en; r[1] = cont; r[3:2] = mult[1:0]; r[6:4] = ps[2:0];
        r[10:7] = sel[3:0]; r[12:11] = lm[1:0]; r[13] = ie; r[14] = keep;
        r[15] = ld; r[16] = sw;
        return r;
    endfunction

    task automatic wait_wrap(output int peak, output int ld_at);
        int prev;
        prev = count;
        peak = -1; ld_at = -1;
        for (int i = 0; i < 100; i++) begin
            step();
            if (wrap_pulse) begin
                peak = prev; ld_at = ldok;
                break;
            end
            prev = count;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog expired actual 0 expected 1");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int pk, la;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R1 count", count, 0);
        chk("R1 start", start_pulse, 0);
        chk("R1 wrap", wrap_pulse, 0);
        chk("R1 flag", irq_flag, 0);
        chk("R1 irq", irq, 0);
        chk("R1 ldok", ldok, 0);

        // immediate load of modulus 1000, delay 500
        wr(1, 17'd1000);
        wr(2, 17'd500);
        wr(0, ctl(1, 0, 0, 0, 15, 0, 0, 1, 1, 0));
        chk("R10 ldok armed", ldok, 1);
        step();
        chk("R11 immediate commit", ldok, 0);

        // rate table
        for (int v = 0; v < 8; v++) begin
            wr(0, ctl(1, 0, VEC[v][0], VEC[v][1], 15, 0, 0, 1, 0, 1));
            step();
            chk("R6 start pulse", start_pulse, 1);
            chk("R6 start count", count, 0);
            repeat (3 * VEC[v][2] - 1) step();
            chk("R3 count before third tick", count, 2);
            step();
            chk("R3 count after third tick", count, 3);
        end

        // disabled
        wr(0, ctl(0, 0, 0, 0, 0, 0, 0, 1, 0, 0));
        step();
        chk("R2 disabled count", count, 0);
        trig_in[0] = 1'b1;
        step(); step();
        chk("R2 trigger ignored start", start_pulse, 0);
        chk("R2 trigger ignored count", count, 0);
        trig_in[0] = 1'b0;

        // hardware select
        wr(0, ctl(1, 0, 0, 0, 3, 0, 0, 1, 0, 0));
        step();
        trig_in[5] = 1'b1;
        step();
        chk("R4 unselected edge", start_pulse, 0);
        step();
        chk("R4 unselected edge later", start_pulse, 0);
        trig_in[3] = 1'b1;
        step();
        chk("R4 selected edge start", start_pulse, 1);
        chk("R4 selected edge count", count, 0);
        repeat (5) step();
        chk("R4 held level no retrigger", count, 5);
        trig_in[3] = 1'b0;
        step();
        trig_in[3] = 1'b1;
        step();
        chk("R6 restart mid-run start", start_pulse, 1);
        chk("R6 restart mid-run count", count, 0);
        wr(0, ctl(1, 0, 0, 0, 5, 0, 0, 1, 0, 0));
        chk("R4 high level on new select", start_pulse, 0);
        step();
        chk("R4 high level on new select later", start_pulse, 0);
        wr(0, ctl(1, 0, 0, 0, 5, 0, 0, 1, 0, 1));
        step();
        chk("R5 sw bit ignored", start_pulse, 0);
        step();
        chk("R5 sw bit ignored later", start_pulse, 0);
        trig_in = '0;

        // continuous and delay flag
        wr(1, 17'd4);
        wr(2, 17'd2);
        wr(0, ctl(1, 1, 0, 0, 15, 0, 0, 1, 1, 0));
        step();
        wr(0, ctl(1, 1, 0, 0, 15, 0, 0, 1, 0, 1));
        step();
        chk("R5 sw start", start_pulse, 1);
        chk("R9 flag at 0", irq_flag, 0);
        step();
        chk("R9 flag at 1", irq_flag, 0);
        step();
        chk("R9 count 2", count, 2);
        chk("R9 flag at delay", irq_flag, 1);
        chk("R9 irq masked", irq, 0);
        step(); step();
        chk("R7 count at modulus", count, 4);
        step();
        chk("R7 wrap count", count, 0);
        chk("R7 wrap pulse", wrap_pulse, 1);
        step();
        chk("R7 after wrap count", count, 1);
        chk("R7 after wrap pulse", wrap_pulse, 0);
        wr(0, ctl(1, 1, 0, 0, 15, 0, 1, 1, 0, 0));
        chk("R9 irq enabled", irq, 1);
        wr(0, ctl(0, 1, 0, 0, 15, 0, 1, 1, 0, 0));
        chk("R9 keep-1 write holds flag", irq_flag, 1);
        wr(0, ctl(0, 1, 0, 0, 15, 0, 1, 0, 0, 0));
        chk("R9 flag cleared", irq_flag, 0);
        chk("R9 irq cleared", irq, 0);

        // one-shot
        wr(1, 17'd3);
        wr(0, ctl(1, 0, 0, 0, 15, 0, 0, 1, 1, 0));
        step();
        wr(0, ctl(1, 0, 0, 0, 15, 0, 0, 1, 0, 1));
        step();
        repeat (3) step();
        chk("R8 reach modulus", count, 3);
        step();
        chk("R8 wrap pulse", wrap_pulse, 1);
        chk("R8 parked", count, 3);
        step();
        chk("R8 single pulse", wrap_pulse, 0);
        repeat (4) step();
        chk("R8 still parked", count, 3);
        wr(0, ctl(1, 0, 0, 0, 15, 0, 0, 1, 0, 1));
        step();
        chk("R8 retrigger count", count, 0);
        chk("R8 retrigger start", start_pulse, 1);

        // buffered modulus, load at modulus
        wr(0, ctl(1, 1, 0, 0, 15, 0, 0, 1, 0, 1));
        wr(1, 17'd6);
        wait_wrap(pk, la);
        chk("R10 buffer not applied", pk, 3);
        wr(0, ctl(1, 1, 0, 0, 15, 1, 0, 1, 1, 0));
        chk("R10 ldok pending", ldok, 1);
        wait_wrap(pk, la);
        chk("R12 ldok clear at wrap", la, 0);
        wait_wrap(pk, la);
        chk("R12 new modulus period", pk, 6);
        wr(0, ctl(0, 1, 0, 0, 15, 1, 0, 1, 1, 0));
        chk("R10 ldok ignored disabled", ldok, 0);
        step();
        chk("R10 ldok ignored disabled later", ldok, 0);

        // load on trigger
        wr(1, 17'd2);
        wr(0, ctl(1, 1, 0, 0, 15, 2, 0, 1, 1, 0));
        repeat (6) step();
        chk("R13 trigger mode waits", ldok, 1);
        wr(0, ctl(1, 1, 0, 0, 15, 2, 0, 1, 0, 1));
        step();
        chk("R13 trigger commit", ldok, 0);
        chk("R13 trigger start", start_pulse, 1);
        wait_wrap(pk, la);
        chk("R13 trigger-loaded modulus", pk, 2);

        // either policy, trigger first
        wr(0, ctl(0, 0, 0, 0, 15, 3, 0, 1, 0, 0));
        wr(1, 17'd5);
        wr(0, ctl(1, 0, 0, 0, 15, 3, 0, 1, 1, 0));
        repeat (4) step();
        chk("R13 either waits", ldok, 1);
        wr(0, ctl(1, 0, 0, 0, 15, 3, 0, 1, 0, 1));
        step();
        chk("R13 either trigger commit", ldok, 0);
        repeat (5) step();
        chk("R13 either new modulus", count, 5);

        // either policy, modulus first
        wr(0, ctl(1, 1, 0, 0, 15, 3, 0, 1, 0, 1));
        wr(1, 17'd2);
        wr(0, ctl(1, 1, 0, 0, 15, 3, 0, 1, 1, 0));
        wait_wrap(pk, la);
        chk("R13 either wrap commit", la, 0);
        wait_wrap(pk, la);
        chk("R13 either wrap modulus", pk, 2);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule